// File: doc/BRIEF.md
# Maskable Interrupt Vectoring Unit

This block sits between three peripheral interrupt requests and the CPU sequencer. The three sources are a serial peripheral interface, a 16-bit programmable timer and a reloadable timer. It combines the requests with one global mask bit and raises an interrupt-pending output whenever an unmasked request is present. Once the sequencer has stacked the machine state, it pulses a take strobe. The block then accepts the interrupt. It latches the 16-bit address of the high byte of the winning source's two-byte vector slot and sets the global mask, so nothing nests until software clears the mask again.

Software controls the mask through set and clear strobes. A return-from-interrupt strobe restores the mask to the value it had when the last interrupt was accepted. Stacking, vector fetch and instruction execution belong to the sequencer and are not part of this block.

Top module: `irq_vector_unit`

## Requirements
- R1: `irq_pending` is 1 exactly when at least one bit of `irq_req` is 1 and `mask` is 0. It follows the inputs combinationally.
- R2: A `take` pulse while `irq_pending` is 1 is an acceptance. `mask` reads 1 from the clock edge that samples it.
- R3: A `take` pulse while `irq_pending` is 0 is ignored. `mask` and `vector_addr` do not change because of it.
- R4: On acceptance, `vector_addr` becomes the high-byte address of the winner's slot. For `irq_req` bit 0 (serial interface) the address is 16'hFFF4. For bit 1 (programmable timer) it is 16'hFFF6. For bit 2 (reloadable timer) it is 16'hFFF8.
- R5: When several requests are active at acceptance, the highest bit index wins. Bit 2 beats bit 1, and bit 1 beats bit 0.
- R6: `vector_addr` changes only on an acceptance. Requests that change after the take leave it unchanged.
- R7: While `rst_n` is 0, `mask` is 1, `vector_addr` is 16'hFFFE and `irq_pending` is 0. The saved mask value is also 1.
- R8: A `rti` pulse without an acceptance in the same cycle sets `mask` to the value `mask` had at the most recent acceptance. If no acceptance has happened since reset, that value is 1.
- R9: With no acceptance and no `rti`, `mask_set` sets `mask` to 1. Otherwise `mask_clr` sets it to 0. `mask_set` wins when both are high. The order of precedence is acceptance, then `rti`, then `mask_set`, then `mask_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 3 | Level requests: bit 0 serial interface, bit 1 programmable timer, bit 2 reloadable timer |
| take | input | 1 | Sequencer strobe: state stacked, take the interrupt now |
| rti | input | 1 | Return-from-interrupt strobe, restores the saved mask |
| mask_set | input | 1 | Set the global mask |
| mask_clr | input | 1 | Clear the global mask |
| irq_pending | output | 1 | An unmasked request is present |
| vector_addr | output | 16 | Address of the high byte of the accepted vector slot |
| mask | output | 1 | Current global mask bit |

## Verification
Single requests on each source check the slot mapping. Random combinations of two or three simultaneous requests show whether the fixed priority picks the highest index or only some active source. Take strobes are issued while masked or with no request, and requests are changed between takes, to separate a correctly latched vector from one that tracks the live inputs. Random mixes of `rti`, `mask_set` and `mask_clr`, including pairs in the same cycle, exercise the precedence order and confirm that `rti` restores the value saved at acceptance.

// File: rtl/irq_vec_pkg.sv
// Package: shared types and helpers for the interrupt vectoring unit.
// Assumes vector slots are contiguous and equally sized, growing upward with source index.
package irq_vec_pkg;

    // Operation applied to the global mask in one cycle, in precedence order.
    typedef enum logic [2:0] {
        MOP_HOLD    = 3'd0,
        MOP_ACCEPT  = 3'd1,
        MOP_RESTORE = 3'd2,
        MOP_SET     = 3'd3,
        MOP_CLEAR   = 3'd4
    } mask_op_e;

    // High-byte address of slot idx, given the lowest slot and the slot size in bytes.
    function automatic logic [15:0] slot_address(input logic [15:0] base,
                                                 input int unsigned idx,
                                                 input int unsigned slot_bytes);
        slot_address = base + 16'(idx * slot_bytes);
    endfunction

endpackage

// File: rtl/irq_src_gate.sv
// Module: gates every source request with the global mask.
// Assumes requests are level signals already synchronous to clk.
module irq_src_gate #(
    parameter int unsigned NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic               mask,
    output logic [NUM_SRC-1:0] eligible
);

    // One gate per source: a request counts only while the mask is clear.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        assign eligible[g] = req[g] & ~mask;
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority picker, the highest set index wins.
// Assumes at most NUM_SRC sources; output index is meaningless when any_valid is 0.
module irq_prio_pick #(
    parameter int unsigned NUM_SRC = 3,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] eligible,
    output logic               any_valid,
    output logic [IDX_W-1:0]   win_idx
);

    // Scan upward so the last (highest) eligible index overwrites lower ones.
    always_comb begin
        any_valid = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eligible[i]) begin
                any_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_mask_ctl.sv
// Module: global mask register and the mask value saved at acceptance.
// Assumes strobes are single-cycle; precedence is accept, restore, set, clear.
module irq_mask_ctl
    import irq_vec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic rti,
    input  logic mask_set,
    input  logic mask_clr,
    output logic mask
);

    mask_op_e op;
    logic     saved_mask;

    // Decode this cycle's strobes into one mask operation by precedence.
    always_comb begin
        if (accept)        op = MOP_ACCEPT;
        else if (rti)      op = MOP_RESTORE;
        else if (mask_set) op = MOP_SET;
        else if (mask_clr) op = MOP_CLEAR;
        else               op = MOP_HOLD;
    end

    // Update the live mask and the copy taken at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask       <= 1'b1;
            saved_mask <= 1'b1;
        end else begin
            unique case (op)
                MOP_ACCEPT: begin
                    saved_mask <= mask;
                    mask       <= 1'b1;
                end
                MOP_RESTORE: mask <= saved_mask;
                MOP_SET:     mask <= 1'b1;
                MOP_CLEAR:   mask <= 1'b0;
                default:     mask <= mask;
            endcase
        end
    end

endmodule

// File: rtl/irq_vec_reg.sv
// Module: holds the vector address of the last accepted interrupt.
// Assumes win_idx is valid whenever accept is high.
module irq_vec_reg
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 3,
    parameter int unsigned SLOT_BYTES = 2,
    parameter logic [15:0] VEC_BASE   = 16'hFFF4,
    parameter logic [15:0] RESET_VEC  = 16'hFFFE,
    localparam int unsigned IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [IDX_W-1:0] win_idx,
    output logic [15:0]      vector_addr
);

    // Capture the winner's slot on acceptance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vector_addr <= RESET_VEC;
        else if (accept)
            vector_addr <= slot_address(VEC_BASE, int'(win_idx), SLOT_BYTES);
    end

endmodule

// File: rtl/irq_vector_unit.sv
// Module: top of the maskable interrupt vectoring unit.
// Gates requests with the global mask, picks the highest-index source, and on a
// take strobe latches its vector address and sets the mask.
// Assumes take is issued by the sequencer only after state stacking.
module irq_vector_unit #(
    parameter int unsigned NUM_SRC    = 3,
    parameter int unsigned SLOT_BYTES = 2,
    parameter logic [15:0] VEC_BASE   = 16'hFFF4,
    parameter logic [15:0] RESET_VEC  = 16'hFFFE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               take,
    input  logic               rti,
    input  logic               mask_set,
    input  logic               mask_clr,
    output logic               irq_pending,
    output logic [15:0]        vector_addr,
    output logic               mask
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] eligible;
    logic [IDX_W-1:0]   win_idx;
    logic               accept;

    irq_src_gate #(.NUM_SRC(NUM_SRC)) i_gate (
        .req      (irq_req),
        .mask     (mask),
        .eligible (eligible)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) i_pick (
        .eligible  (eligible),
        .any_valid (irq_pending),
        .win_idx   (win_idx)
    );

    // Acceptance: the sequencer takes while an unmasked request is present.
    assign accept = take & irq_pending;

    irq_mask_ctl i_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .rti      (rti),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .mask     (mask)
    );

    irq_vec_reg #(
        .NUM_SRC    (NUM_SRC),
        .SLOT_BYTES (SLOT_BYTES),
        .VEC_BASE   (VEC_BASE),
        .RESET_VEC  (RESET_VEC)
    ) i_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .win_idx     (win_idx),
        .vector_addr (vector_addr)
    );

endmodule

// File: rtl/irq_vector_unit_chk.sv
// Module: assertion checker for irq_vector_unit, attached by bind.
// Assumes the default slot layout parameters of the top module.
module irq_vector_unit_chk #(
    parameter int unsigned NUM_SRC    = 3,
    parameter int unsigned SLOT_BYTES = 2,
    parameter logic [15:0] VEC_BASE   = 16'hFFF4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               take,
    input logic               rti,
    input logic               mask_set,
    input logic               mask_clr,
    input logic               irq_pending,
    input logic [15:0]        vector_addr,
    input logic               mask
);

    localparam logic [15:0] TOP_SLOT = VEC_BASE + 16'((NUM_SRC - 1) * SLOT_BYTES);
    localparam logic [15:0] SPAN     = 16'(NUM_SRC * SLOT_BYTES);

    assert_pending_rule_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending == ((|irq_req) && !mask));

    assert_accept_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_pending) |=> mask);

    assert_idle_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !irq_pending && !rti && !mask_set && !mask_clr)
        |=> ($stable(mask) && $stable(vector_addr)));

    assert_legal_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_pending)
        |=> ((16'(vector_addr - VEC_BASE) < SPAN) && (vector_addr[0] == VEC_BASE[0])));

    assert_top_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_pending && irq_req[NUM_SRC-1]) |=> (vector_addr == TOP_SLOT));

    assert_vector_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && irq_pending) |=> $stable(vector_addr));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set && !take && !rti) |=> mask);

    assert_clear_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr && !mask_set && !take && !rti) |=> !mask);

endmodule

bind irq_vector_unit irq_vector_unit_chk #(
    .NUM_SRC    (NUM_SRC),
    .SLOT_BYTES (SLOT_BYTES),
    .VEC_BASE   (VEC_BASE)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .take        (take),
    .rti         (rti),
    .mask_set    (mask_set),
    .mask_clr    (mask_clr),
    .irq_pending (irq_pending),
    .vector_addr (vector_addr),
    .mask        (mask)
);

// File: tb/test_irq_vector_unit.sv
`timescale 1ns/1ps
// Bench: random and directed stimulus against a behavioural model of the requirements.
module test_irq_vector_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_req = '0;
    logic        take = 1'b0;
    logic        rti = 1'b0;
    logic        mask_set = 1'b0;
    logic        mask_clr = 1'b0;
    logic        irq_pending;
    logic [15:0] vector_addr;
    logic        mask;

    int total = 0;
    int bad   = 0;

    // Model state.
    logic        m_mask  = 1'b1;
    logic        m_saved = 1'b1;
    logic [15:0] m_vec   = 16'hFFFE;

    always #2.5 clk = ~clk;

    irq_vector_unit i_irq_vector_unit (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .take(take), .rti(rti),
        .mask_set(mask_set), .mask_clr(mask_clr),
        .irq_pending(irq_pending), .vector_addr(vector_addr), .mask(mask)
    );

    // Slot address of the highest active request (R4, R5).
    function automatic logic [15:0] exp_slot(input logic [2:0] r);
        if (r[2])      return 16'hFFF8;
        else if (r[1]) return 16'hFFF6;
        else           return 16'hFFF4;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check pending, apply edge, check registers.
    task automatic step(input logic [2:0] r, input logic tk, input logic rt,
                        input logic st, input logic cl);
        logic  acc;
        string mtag;
        string vtag;
        @(negedge clk);
        irq_req = r; take = tk; rti = rt; mask_set = st; mask_clr = cl;
        #1;
        check("R1 pending", 16'(irq_pending), 16'((|r) && !m_mask));
        acc  = tk && (|r) && !m_mask;
        vtag = acc ? (($countones(r) > 1) ? "R5 priority" : "R4 slot") : "R6 hold";
        if (acc) begin
            m_saved = m_mask; m_mask = 1'b1; m_vec = exp_slot(r); mtag = "R2 accept";
        end else if (rt) begin
            m_mask = m_saved; mtag = "R8 restore";
        end else if (st) begin
            m_mask = 1'b1; mtag = "R9 set";
        end else if (cl) begin
            m_mask = 1'b0; mtag = "R9 clear";
        end else begin
            mtag = tk ? "R3 ignored take" : "R9 hold";
        end
        @(posedge clk);
        #1;
        check(mtag, 16'(mask), 16'(m_mask));
        check(vtag, vector_addr, m_vec);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        irq_req = 3'b111;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset mask", 16'(mask), 16'd1);
        check("R7 reset vector", vector_addr, 16'hFFFE);
        check("R7 reset pending", 16'(irq_pending), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: rti before any acceptance restores the reset value 1.
        step(3'b000, 0, 0, 0, 1);
        step(3'b000, 0, 1, 0, 0);
        // R3: take while masked is ignored.
        step(3'b001, 1, 0, 0, 0);
        // R4: each source alone.
        step(3'b000, 0, 0, 0, 1);
        step(3'b001, 1, 0, 0, 0);
        step(3'b000, 0, 1, 0, 0);
        step(3'b010, 1, 0, 0, 0);
        step(3'b000, 0, 1, 0, 0);
        step(3'b100, 1, 0, 0, 0);
        // R6: requests change after the take, vector stays.
        step(3'b011, 0, 0, 0, 0);
        step(3'b000, 0, 1, 0, 0);
        // R3: take with no request.
        step(3'b000, 1, 0, 0, 0);
        // R5: all pending at once.
        step(3'b111, 1, 0, 0, 0);
        step(3'b011, 0, 1, 0, 0);
        step(3'b011, 1, 0, 0, 0);
        // R9: set beats clear; precedence of rti over set.
        step(3'b000, 0, 0, 1, 1);
        step(3'b000, 0, 1, 1, 0);

        for (int i = 0; i < 3000; i++) begin
            step(3'($urandom_range(0, 7)),
                 ($urandom_range(0, 2) == 0),
                 ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 3) == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule